// File: doc/BRIEF.md
# Deficit Weighted Round-Robin Packet Arbiter

This block merges several packet sources onto one upstream bus. Each source offers whole packets over a valid/ready interface with start and end markers. Every beat carries a wide data word and a narrower control word, and the packet length in beats sits in the low bits of the control word. The arbiter gives the bus to one source at a time for a complete packet, so packets never interleave. It picks sources by deficit weighted round robin, using one static weight (quantum) per source.

A pointer walks the sources one per cycle while no packet is in flight. When it lands on a source with a packet waiting, that source's quantum is added to its deficit. If the new deficit is positive, the source is granted. The grant does not depend on whether the credit covers the whole packet: when the packet ends, its full length is subtracted, and the deficit may go negative. A source the pointer finds idle has its deficit cleared, so it cannot bank credit. While a packet is in flight the granted source's beats pass straight through to the output. The source's ready follows the output ready. After the last beat the pointer moves past the granted source.

Top module: `drr_pkt_arbiter`

## Requirements
- R1: While reset is applied and right after it, `out_valid_o` is low, every `in_ready_o` bit is low, every deficit is zero and the pointer is at source 0.
- R2: In each cycle with no packet in flight, the source under the pointer is visited. If it shows valid with start-of-packet, its quantum is added to its deficit, and it is granted when the result is greater than zero. Otherwise the pointer advances by one, wrapping after the last source.
- R3: A visited source that shows no pending packet has its deficit set to zero. A source that went negative and then idled is therefore granted again at its first pending visit.
- R4: A positive deficit grants a whole packet of any length (insolvency). The length is charged when the end-of-packet beat is accepted, and the deficit may go negative.
- R5: The packet length in beats is read from control bits [LEN_W-1:0] (bits [8:0] by default) of the start-of-packet beat. It is charged on the end beat, including when start and end fall on the same beat.
- R6: A granted packet owns the output from its start beat to its end beat. `out_chan_o` does not change in between, no other source's ready goes high, and at most one `in_ready_o` bit is high, and only when `out_ready_i` is high.
- R7: After the end beat is accepted, the pointer moves to the source after the granted one, wrapping from the last source to source 0.
- R8: While granted, the output valid, start, end, data and control words equal those of the granted source in the same cycle, and `out_chan_o` gives its index.
- R9: A source whose quantum is zero and whose deficit is zero is never granted, even with packets waiting.
- R10: The quantum is added with saturation at 2^(DEF_W-1)-1, where DEF_W = max(QW, LEN_W)+2. This is 2047 by default. The deficit therefore never wraps when a heavily weighted source sends short packets.
- R11: With no source requesting, `out_valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| quanta_i | input | N_CH*QW | Static quantum per source, source c at bits [c*QW +: QW] |
| in_valid_i | input | N_CH | Beat valid per source |
| in_sop_i | input | N_CH | Start-of-packet marker per source |
| in_eop_i | input | N_CH | End-of-packet marker per source |
| in_data_i | input | N_CH*DATA_W | Data word per source |
| in_ctrl_i | input | N_CH*CTRL_W | Control word per source; bits [LEN_W-1:0] carry the length at start |
| in_ready_o | output | N_CH | Ready per source |
| out_valid_o | output | 1 | Output beat valid |
| out_sop_o | output | 1 | Output start-of-packet |
| out_eop_o | output | 1 | Output end-of-packet |
| out_data_o | output | DATA_W | Output data word |
| out_ctrl_o | output | CTRL_W | Output control word |
| out_chan_o | output | IDX_W | Index of the granted source |
| out_ready_i | input | 1 | Downstream ready |

## Verification
Two things can land in the same cycle. A single-beat packet has its length captured and its deficit charged on one accepted beat. A grant decision also adds the quantum and tests the sum in one visit. Both are provoked by random lengths that include one-beat packets and by uneven quanta. They are judged by the packet order at the output, which a bench model of the weighted rotation predicts. Insolvency and idle clearing are judged by how many cycles pass before a negative-credit source is granted again, and saturation by whether a heavily weighted source keeps its turn on every round.

// File: rtl/drr_pkg.sv
package drr_pkg;
  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_XFER = 1'b1
  } arb_state_e;
endpackage

// File: rtl/drr_credit_bank.sv
module drr_credit_bank #(
  parameter int N_CH  = 4,
  parameter int QW    = 10,
  parameter int LEN_W = 9,
  parameter int DEF_W = 12,
  parameter int IDX_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_CH*QW-1:0]   quanta_i,
  input  logic                 visit_i,
  input  logic [IDX_W-1:0]     visit_idx_i,
  input  logic                 visit_pend_i,
  input  logic                 charge_i,
  input  logic [IDX_W-1:0]     charge_idx_i,
  input  logic [LEN_W-1:0]     charge_len_i,
  output logic                 credit_ok_o
);
  localparam int SW = DEF_W + 1;
  localparam logic signed [SW-1:0] DMAX = SW'(2 ** (DEF_W - 1) - 1);

  logic [DEF_W-1:0] def_w [N_CH];
  logic [DEF_W-1:0] def_sel;
  logic [QW-1:0]    q_sel;
  logic signed [SW-1:0] sum_w;
  logic [DEF_W-1:0] sat_w;

  assign def_sel = def_w[visit_idx_i];
  assign q_sel   = quanta_i[visit_idx_i*QW +: QW];
  assign sum_w   = $signed({def_sel[DEF_W-1], def_sel}) + $signed({{(SW-QW){1'b0}}, q_sel});
  assign sat_w   = (sum_w > DMAX) ? DMAX[DEF_W-1:0] : sum_w[DEF_W-1:0];
  assign credit_ok_o = !sat_w[DEF_W-1] && (sat_w != '0);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [DEF_W-1:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
      end else if (visit_i && visit_idx_i == IDX_W'(c)) begin
        d_q <= visit_pend_i ? sat_w : '0;
      end else if (charge_i && charge_idx_i == IDX_W'(c)) begin
        d_q <= d_q - {{(DEF_W-LEN_W){1'b0}}, charge_len_i};
      end
    end
    assign def_w[c] = d_q;
  end
endmodule

// File: rtl/drr_sched.sv
module drr_sched
  import drr_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int LEN_W = 9,
  parameter int IDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   in_valid_i,
  input  logic [N_CH-1:0]   in_sop_i,
  input  logic              credit_ok_i,
  input  logic              beat_hs_i,
  input  logic              beat_sop_i,
  input  logic              beat_eop_i,
  input  logic [LEN_W-1:0]  beat_len_i,
  output logic              visit_o,
  output logic [IDX_W-1:0]  ptr_o,
  output logic              pend_o,
  output logic              charge_o,
  output logic [LEN_W-1:0]  charge_len_o,
  output logic              busy_o
);
  arb_state_e       st_q;
  logic [IDX_W-1:0] ptr_q, ptr_nx;
  logic [LEN_W-1:0] len_q;
  logic             grant;

  assign ptr_nx  = (ptr_q == IDX_W'(N_CH - 1)) ? '0 : ptr_q + 1'b1;
  assign pend_o  = in_valid_i[ptr_q] & in_sop_i[ptr_q];
  assign visit_o = (st_q == ST_SCAN);
  assign grant   = visit_o & pend_o & credit_ok_i;
  assign busy_o  = (st_q == ST_XFER);
  assign ptr_o   = ptr_q;
  // single-beat packets charge the length seen on this very beat
  assign charge_o     = busy_o & beat_hs_i & beat_eop_i;
  assign charge_len_o = beat_sop_i ? beat_len_i : len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_SCAN;
      ptr_q <= '0;
      len_q <= '0;
    end else begin
      unique case (st_q)
        ST_SCAN: begin
          if (grant) st_q <= ST_XFER;
          else       ptr_q <= ptr_nx;
        end
        ST_XFER: begin
          if (beat_hs_i && beat_sop_i) len_q <= beat_len_i;
          if (beat_hs_i && beat_eop_i) begin
            st_q  <= ST_SCAN;
            ptr_q <= ptr_nx;
          end
        end
        default: st_q <= ST_SCAN;
      endcase
    end
  end
endmodule

// File: rtl/drr_out_mux.sv
module drr_out_mux #(
  parameter int N_CH   = 4,
  parameter int DATA_W = 128,
  parameter int CTRL_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic                   busy_i,
  input  logic [IDX_W-1:0]       sel_i,
  input  logic [N_CH-1:0]        in_valid_i,
  input  logic [N_CH-1:0]        in_sop_i,
  input  logic [N_CH-1:0]        in_eop_i,
  input  logic [N_CH*DATA_W-1:0] in_data_i,
  input  logic [N_CH*CTRL_W-1:0] in_ctrl_i,
  input  logic                   out_ready_i,
  output logic [N_CH-1:0]        in_ready_o,
  output logic                   out_valid_o,
  output logic                   out_sop_o,
  output logic                   out_eop_o,
  output logic [DATA_W-1:0]      out_data_o,
  output logic [CTRL_W-1:0]      out_ctrl_o
);
  assign out_valid_o = busy_i & in_valid_i[sel_i];
  assign out_sop_o   = in_sop_i[sel_i];
  assign out_eop_o   = in_eop_i[sel_i];
  assign out_data_o  = in_data_i[sel_i*DATA_W +: DATA_W];
  assign out_ctrl_o  = in_ctrl_i[sel_i*CTRL_W +: CTRL_W];

  for (genvar c = 0; c < N_CH; c++) begin : g_rdy
    assign in_ready_o[c] = busy_i & out_ready_i & (sel_i == IDX_W'(c));
  end
endmodule

// File: rtl/drr_pkt_arbiter.sv
module drr_pkt_arbiter #(
  parameter int N_CH   = 4,
  parameter int DATA_W = 128,
  parameter int CTRL_W = 16,
  parameter int LEN_W  = 9,
  parameter int QW     = 10,
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int DEF_W = ((QW > LEN_W) ? QW : LEN_W) + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH*QW-1:0]     quanta_i,
  input  logic [N_CH-1:0]        in_valid_i,
  input  logic [N_CH-1:0]        in_sop_i,
  input  logic [N_CH-1:0]        in_eop_i,
  input  logic [N_CH*DATA_W-1:0] in_data_i,
  input  logic [N_CH*CTRL_W-1:0] in_ctrl_i,
  output logic [N_CH-1:0]        in_ready_o,
  output logic                   out_valid_o,
  output logic                   out_sop_o,
  output logic                   out_eop_o,
  output logic [DATA_W-1:0]      out_data_o,
  output logic [CTRL_W-1:0]      out_ctrl_o,
  output logic [IDX_W-1:0]       out_chan_o,
  input  logic                   out_ready_i
);
  logic             visit, pend, credit_ok, charge, busy, beat_hs;
  logic [IDX_W-1:0] ptr;
  logic [LEN_W-1:0] charge_len;

  assign beat_hs    = out_valid_o & out_ready_i;
  assign out_chan_o = ptr;

  drr_sched #(.N_CH(N_CH), .LEN_W(LEN_W), .IDX_W(IDX_W)) sched_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_sop_i     (in_sop_i),
    .credit_ok_i  (credit_ok),
    .beat_hs_i    (beat_hs),
    .beat_sop_i   (out_sop_o),
    .beat_eop_i   (out_eop_o),
    .beat_len_i   (out_ctrl_o[LEN_W-1:0]),
    .visit_o      (visit),
    .ptr_o        (ptr),
    .pend_o       (pend),
    .charge_o     (charge),
    .charge_len_o (charge_len),
    .busy_o       (busy)
  );

  drr_credit_bank #(.N_CH(N_CH), .QW(QW), .LEN_W(LEN_W), .DEF_W(DEF_W), .IDX_W(IDX_W)) bank_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .quanta_i     (quanta_i),
    .visit_i      (visit),
    .visit_idx_i  (ptr),
    .visit_pend_i (pend),
    .charge_i     (charge),
    .charge_idx_i (ptr),
    .charge_len_i (charge_len),
    .credit_ok_o  (credit_ok)
  );

  drr_out_mux #(.N_CH(N_CH), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .IDX_W(IDX_W)) mux_i (
    .busy_i      (busy),
    .sel_i       (ptr),
    .in_valid_i  (in_valid_i),
    .in_sop_i    (in_sop_i),
    .in_eop_i    (in_eop_i),
    .in_data_i   (in_data_i),
    .in_ctrl_i   (in_ctrl_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_sop_o   (out_sop_o),
    .out_eop_o   (out_eop_o),
    .out_data_o  (out_data_o),
    .out_ctrl_o  (out_ctrl_o)
  );
endmodule

// File: rtl/drr_pkt_arbiter_chk.sv
module drr_pkt_arbiter_chk #(
  parameter int N_CH  = 4,
  parameter int IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CH-1:0]  in_valid_i,
  input logic [N_CH-1:0]  in_ready_o,
  input logic             out_valid_o,
  input logic             out_sop_o,
  input logic             out_eop_o,
  input logic [IDX_W-1:0] out_chan_o,
  input logic             out_ready_i
);
  logic             in_pkt_q;
  logic [IDX_W-1:0] chan_q;
  logic             hs;

  assign hs = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      chan_q   <= '0;
    end else if (hs) begin
      if (out_eop_o) in_pkt_q <= 1'b0;
      else if (out_sop_o) begin
        in_pkt_q <= 1'b1;
        chan_q   <= out_chan_o;
      end
    end
  end

  p_ready_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_ready_o));
  p_ready_needs_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|in_ready_o) |-> out_ready_i);
  p_chan_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pkt_q |-> (out_chan_o == chan_q));
  p_first_is_sop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !in_pkt_q) |-> out_sop_o);
  p_no_mid_sop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && in_pkt_q) |-> !out_sop_o);
  p_src_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |-> (in_ready_o[out_chan_o] && in_valid_i[out_chan_o]));
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i == '0) |-> !out_valid_o);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (!out_valid_o && in_ready_o == '0) || !rst_ni);
endmodule

bind drr_pkt_arbiter drr_pkt_arbiter_chk #(.N_CH(N_CH), .IDX_W(IDX_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_sop_o   (out_sop_o),
  .out_eop_o   (out_eop_o),
  .out_chan_o  (out_chan_o),
  .out_ready_i (out_ready_i)
);

// File: tb/drr_pkt_arbiter_tb.sv
module drr_pkt_arbiter_tb_top;
  localparam int N = 4, DW = 128, CW = 16, LW = 9, QW = 10, IW = 2;
  localparam int MAXP = 16;
  localparam int DMAX = 2047;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N*QW-1:0] quanta;
  logic [N-1:0]    in_valid, in_sop, in_eop, in_ready;
  logic [N*DW-1:0] in_data;
  logic [N*CW-1:0] in_ctrl;
  logic            out_valid, out_sop, out_eop, out_ready;
  logic [DW-1:0]   out_data;
  logic [CW-1:0]   out_ctrl;
  logic [IW-1:0]   out_chan;

  drr_pkt_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .quanta_i(quanta),
    .in_valid_i(in_valid), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .in_data_i(in_data), .in_ctrl_i(in_ctrl), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_sop_o(out_sop), .out_eop_o(out_eop),
    .out_data_o(out_data), .out_ctrl_o(out_ctrl), .out_chan_o(out_chan),
    .out_ready_i(out_ready));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int q[N];
  int nq[N], hd[N], bt[N], seen[N];
  int lenq[N][MAXP];
  int exp_ch[512], exp_len[512];
  int n_exp, n_out, ob, first_v, cyc;
  logic [N-1:0] hs;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int c, input int k, input int b);
    return {96'h0, 8'(c), 8'(k), 16'(b)};
  endfunction
  function automatic logic [CW-1:0] ctl(input int c, input int k);
    return {7'((c + k) % 5), 9'(lenq[c][k])};
  endfunction

  task automatic drive();
    for (int c = 0; c < N; c++) begin
      quanta[c*QW +: QW] = QW'(q[c]);
      in_valid[c] = hd[c] < nq[c];
      in_sop[c]   = in_valid[c] && bt[c] == 0;
      in_eop[c]   = in_valid[c] && bt[c] == lenq[c][hd[c] % MAXP] - 1;
      in_data[c*DW +: DW] = in_valid[c] ? pat(c, hd[c], bt[c]) : '0;
      in_ctrl[c*CW +: CW] = in_valid[c] ? ctl(c, hd[c]) : '0;
    end
  endtask

  task automatic do_reset();
    for (int c = 0; c < N; c++) begin nq[c] = 0; hd[c] = 0; bt[c] = 0; seen[c] = 0; end
    out_ready = 1'b0;
    drive();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: idle outputs while in reset
    chk(!out_valid && in_ready == '0, "R1 reset outputs", {out_valid, in_ready}, 0);
    rst_n = 1'b1;
  endtask

  // weighted rotation model, starting from zero credit and pointer 0
  task automatic build_model();
    int d[N], rem[N], idx[N], p, total;
    p = 0; n_exp = 0; total = 0;
    for (int c = 0; c < N; c++) begin
      d[c] = 0; rem[c] = nq[c] - hd[c]; idx[c] = hd[c];
      if (q[c] > 0) total += rem[c];
    end
    for (int v = 0; v < 40000 && n_exp < total; v++) begin
      if (rem[p] > 0) begin
        d[p] = d[p] + q[p];
        if (d[p] > DMAX) d[p] = DMAX;
        if (d[p] > 0) begin
          exp_ch[n_exp] = p; exp_len[n_exp] = lenq[p][idx[p]]; n_exp++;
          d[p] -= lenq[p][idx[p]]; idx[p]++; rem[p]--;
        end
      end else d[p] = 0;
      p = (p + 1) % N;
    end
  endtask

  task automatic run_phase(input bit rnd_ready, input int maxc);
    bit bad_rdy = 0;
    n_out = 0; ob = 0; first_v = -1; cyc = 0;
    drive();
    while (n_out < n_exp && cyc < maxc) begin
      @(negedge clk);
      if (out_valid && first_v < 0) first_v = cyc;
      for (int c = 0; c < N; c++) begin
        hs[c] = in_valid[c] & in_ready[c];
        if (in_ready[c] && int'(out_chan) != c) bad_rdy = 1;
      end
      if (out_valid && out_ready) begin
        int ec, k;
        ec = exp_ch[n_out];
        k  = seen[ec];
        chk(int'(out_chan) == ec, "R2 grant order", out_chan, ec);
        chk(out_sop == (ob == 0) && out_eop == (ob == exp_len[n_out] - 1),
            "R6 packet markers", {out_sop, out_eop}, {ob == 0, ob == exp_len[n_out] - 1});
        chk(out_data == pat(ec, k, ob) && out_ctrl == ctl(ec, k),
            "R8 passthrough", out_data[31:0], pat(ec, k, ob) & 32'hffffffff);
        if (ob == exp_len[n_out] - 1) begin ob = 0; n_out++; seen[ec]++; end
        else ob++;
      end
      @(posedge clk);
      #1;
      for (int c = 0; c < N; c++)
        if (hs[c]) begin
          if (bt[c] == lenq[c][hd[c]] - 1) begin bt[c] = 0; hd[c]++; end
          else bt[c]++;
        end
      out_ready = rnd_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
      drive();
      cyc++;
    end
    chk(n_out == n_exp, "R7 all packets delivered", n_out, n_exp);
    chk(!bad_rdy, "R6 only granted ready", bad_rdy, 0);
  endtask

  task automatic load(input int c, input int cnt, input int lmin, input int lmax);
    for (int k = 0; k < cnt; k++) lenq[c][nq[c] + k] = $urandom_range(lmin, lmax);
    nq[c] += cnt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7713));
    for (int c = 0; c < N; c++) q[c] = 4;
    do_reset();

    // equal weights, one-beat packets included (R2, R5)
    for (int c = 0; c < N; c++) load(c, 6, 1, 8);
    build_model(); run_phase(1, 5000);

    // uneven weights with a zero-quantum source (R2, R9)
    q[0] = 8; q[1] = 3; q[2] = 1; q[3] = 0;
    do_reset();
    for (int c = 0; c < N; c++) load(c, 8, 1, 6);
    build_model(); run_phase(1, 8000);
    chk(hd[3] == 0, "R9 zero quantum never granted", hd[3], 0);

    // insolvency then idle clear (R4, R3, R11)
    q[0] = 4; q[1] = 1; q[2] = 4; q[3] = 4;
    do_reset();
    nq[1] = 0; lenq[1][0] = 8; nq[1] = 1;
    build_model(); run_phase(0, 200);
    chk(first_v >= 0 && first_v <= N + 2, "R4 insolvent grant latency", first_v, N + 2);
    begin
      bit any_v = 0;
      repeat (20) begin @(negedge clk); if (out_valid) any_v = 1; end
      chk(!any_v, "R11 idle output low", any_v, 0);
    end
    @(posedge clk); #1;
    lenq[1][1] = 2; nq[1] = 2;
    build_model(); run_phase(0, 200);
    chk(first_v >= 0 && first_v <= N + 2, "R3 cleared debt regrant latency", first_v, N + 2);

    // heavy quantum with short packets keeps its turn (R10)
    q[0] = 1023; q[1] = 1; q[2] = 0; q[3] = 0;
    do_reset();
    load(0, 8, 1, 1); load(1, 8, 1, 1);
    build_model(); run_phase(0, 2000);
    chk(exp_ch[4] == 0 && exp_ch[5] == 1, "R10 saturated credit order", exp_ch[4], 0);

    // random mixes
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < N; c++) q[c] = $urandom_range(1, 12);
      do_reset();
      for (int c = 0; c < N; c++) load(c, $urandom_range(0, 10), 1, 10);
      build_model(); run_phase(1, 20000);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule